// File: doc/BRIEF.md
# Alternating A/B Pattern Sequencer

This block stores two bit patterns, A and B, each in its own memory bank, and plays them out serially at one bit per clock. In counting mode it sends pattern A a programmed number of passes, then pattern B a programmed number of passes, and repeats that cycle for as long as it runs. A typical use is to alternate a normal stream with an alarm stream toward a device, so that its reaction to the alarm can be measured.

In external mode the loop counters are ignored. At the end of every pass, a synchronised external select line chooses which pattern follows. Whatever the mode, a change of pattern happens only at a pass boundary. Every pass is marked by a one-cycle sync pulse on its first bit, and a flag beside the data shows which pattern that bit came from.

Pattern lengths are given in bits and used in whole segments of 128 bits. The bank capacity is a parameter. A length register can cover up to 4,194,304 bits, and anything beyond the bank capacity is clamped to it.

Top module: `alt_pattern_seq`

## Requirements
- R1: While `rst_n` is low, and on the clock edge after any edge that samples `run` low, `dv`, `dout`, `sync` and `pat_is_b` are all 0.
- R2: On the first edge that samples `run` high after it was low, the outputs carry bit 0 of pattern A with `dv`=1, `sync`=1 and `pat_is_b`=0. After that, one bit per clock comes out in rising bit index order.
- R3: A write with `wr_en`=1 stores `wr_data` into bank A (`wr_bank`=0) or bank B (`wr_bank`=1) at word `wr_addr`. Bit j of word w is pattern bit w*WORD_W+j.
- R4: A pass is `len` rounded down to a multiple of 128 bits long. Any `len` below 128 gives a 128-bit pass.
- R5: A length above the bank capacity (MAX_SEGS*128 bits) is clamped to the capacity.
- R6: With `ext_mode`=0, the stream runs A for `loops_a` passes, then B for `loops_b` passes, and repeats this forever.
- R7: A loop count of 0 behaves as a count of 1.
- R8: With `ext_mode`=1, the pattern after each pass is A when the synchronised `ext_sel` is 0 and B when it is 1, whatever the loop counts. `ext_sel` passes through SYNC_STAGES flops and must be steady for that many cycles before the last bit of a pass.
- R9: `pat_is_b` never changes in the middle of a pass. Between two consecutive valid bits it changes only when the second bit carries `sync`.
- R10: `sync` is 1 exactly on the first bit of every pass, repeated passes included, and only when `dv`=1.
- R11: Lowering `run` in the middle of a pass stops output on the next edge. The next run starts again at bit 0 of pattern A, on its first pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Pattern memory write strobe |
| wr_bank | input | 1 | Bank to write: 0 = A, 1 = B |
| wr_addr | input | ADDR_W | Word index inside the bank |
| wr_data | input | WORD_W | Word to store |
| len_a | input | LEN_W | Length of pattern A in bits |
| len_b | input | LEN_W | Length of pattern B in bits |
| loops_a | input | LOOP_W | Number of A passes per cycle |
| loops_b | input | LOOP_W | Number of B passes per cycle |
| run | input | 1 | Play enable; low returns to the start point |
| ext_mode | input | 1 | 1 = the external select picks the next pattern |
| ext_sel | input | 1 | External pattern select (0 = A, 1 = B), asynchronous |
| dout | output | 1 | Serial pattern bit |
| dv | output | 1 | `dout` holds a valid bit |
| sync | output | 1 | First bit of a pass |
| pat_is_b | output | 1 | Current bit belongs to pattern B |

## Verification
The bench builds the block with its default parameters: 128-bit segments, a capacity of four segments (512 bits per bank), 32-bit write words, 23-bit length registers, 7-bit loop counts and two synchroniser stages. With banks this small, rounding, clamping of the maximum 4,194,304-bit length and the full 127-pass loop count all fit into a short run. Random lengths and counts, together with random external selects changed in the middle of a pass, test the rule that switching happens only at pass boundaries against a bench model that predicts every bit.

// File: rtl/alt_pat_pkg.sv
package alt_pat_pkg;

   typedef enum logic {
      PAT_A = 1'b0,
      PAT_B = 1'b1
   } pat_sel_e;

   localparam int unsigned SEG_BITS_DEF = 128;
   localparam int unsigned LOOP_W_DEF   = 7;

endpackage

// File: rtl/alt_len_decode.sv
module alt_len_decode #(
   parameter int unsigned SEG_BITS = 128,
   parameter int unsigned MAX_SEGS = 4,
   parameter int unsigned LEN_W    = 23,
   parameter int unsigned LOOP_W   = 7,
   localparam int unsigned IDX_W   = $clog2(SEG_BITS * MAX_SEGS)
) (
   input  logic [LEN_W-1:0]  len_i,
   input  logic [LOOP_W-1:0] loops_i,
   output logic [IDX_W-1:0]  last_idx_o,
   output logic [LOOP_W-1:0] loops_o
);

   localparam int unsigned SEG_SH = $clog2(SEG_BITS);
   localparam int unsigned SEGC_W = $clog2(MAX_SEGS + 1);
   localparam logic [LEN_W-1:0] MAX_SEGS_L = LEN_W'(MAX_SEGS);

   logic [LEN_W-1:0]         segs_raw;
   logic [SEGC_W-1:0]        segs;
   logic [SEGC_W+SEG_SH-1:0] nbits;

   always_comb begin
      segs_raw = len_i >> SEG_SH;
      if (segs_raw == '0) begin
         segs = SEGC_W'(1);
      end else if (segs_raw > MAX_SEGS_L) begin
         segs = SEGC_W'(MAX_SEGS);
      end else begin
         segs = SEGC_W'(segs_raw);
      end
      nbits      = {segs, {SEG_SH{1'b0}}};
      last_idx_o = IDX_W'(nbits - 1'b1);
   end

   assign loops_o = (loops_i == '0) ? LOOP_W'(1) : loops_i;

endmodule

// File: rtl/alt_pat_mem.sv
module alt_pat_mem #(
   parameter int unsigned WORD_W    = 32,
   parameter int unsigned BANK_BITS = 512,
   localparam int unsigned WPB      = BANK_BITS / WORD_W,
   localparam int unsigned ADDR_W   = $clog2(WPB),
   localparam int unsigned IDX_W    = $clog2(BANK_BITS)
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic              wr_bank,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [WORD_W-1:0] wr_data,
   input  logic              rd_bank,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic              rd_bit
);

   wire [BANK_BITS-1:0] flat [2];

   for (genvar b = 0; b < 2; b++) begin : g_bank
      for (genvar w = 0; w < WPB; w++) begin : g_word
         logic [WORD_W-1:0] word_q;
         always_ff @(posedge clk) begin
            if (wr_en && (wr_bank == 1'(b)) && (wr_addr == ADDR_W'(w))) begin
               word_q <= wr_data;
            end
         end
         assign flat[b][w*WORD_W +: WORD_W] = word_q;
      end
   end

   assign rd_bit = rd_bank ? flat[1][rd_idx] : flat[0][rd_idx];

endmodule

// File: rtl/alt_sync.sv
module alt_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);

   if (STAGES == 0) begin : g_bypass
      assign q_o = d_i;
   end else begin : g_chain
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            chain_q <= '0;
         end else if (STAGES == 1) begin
            chain_q <= STAGES'(d_i);
         end else begin
            chain_q <= STAGES'({chain_q, d_i});
         end
      end
      assign q_o = chain_q[STAGES-1];
   end

endmodule

// File: rtl/alt_seq_ctrl.sv
module alt_seq_ctrl
   import alt_pat_pkg::*;
#(
   parameter int unsigned IDX_W  = 9,
   parameter int unsigned LOOP_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              ext_mode,
   input  logic              ext_sel_s,
   input  logic [IDX_W-1:0]  last_a,
   input  logic [IDX_W-1:0]  last_b,
   input  logic [LOOP_W-1:0] loops_a,
   input  logic [LOOP_W-1:0] loops_b,
   output pat_sel_e          cur_pat,
   output logic [IDX_W-1:0]  cur_idx,
   output logic              first_bit
);

   pat_sel_e          pat_q;
   logic [IDX_W-1:0]  idx_q;
   logic [LOOP_W-1:0] pass_q;
   logic [IDX_W-1:0]  last_cur;
   logic [LOOP_W:0]   loops_cur;
   logic [LOOP_W:0]   pass_next;

   always_comb begin
      last_cur  = (pat_q == PAT_B) ? last_b : last_a;
      loops_cur = {1'b0, ((pat_q == PAT_B) ? loops_b : loops_a)};
      pass_next = {1'b0, pass_q} + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || !run) begin
         pat_q  <= PAT_A;
         idx_q  <= '0;
         pass_q <= '0;
      end else if (idx_q == last_cur) begin
         idx_q <= '0;
         if (ext_mode) begin
            pat_q  <= ext_sel_s ? PAT_B : PAT_A;
            pass_q <= '0;
         end else if (pass_next >= loops_cur) begin
            pat_q  <= (pat_q == PAT_A) ? PAT_B : PAT_A;
            pass_q <= '0;
         end else begin
            pass_q <= pass_next[LOOP_W-1:0];
         end
      end else begin
         idx_q <= idx_q + 1'b1;
      end
   end

   assign cur_pat   = pat_q;
   assign cur_idx   = idx_q;
   assign first_bit = (idx_q == '0);

endmodule

// File: rtl/alt_pattern_seq.sv
module alt_pattern_seq
   import alt_pat_pkg::*;
#(
   parameter int unsigned SEG_BITS    = SEG_BITS_DEF,
   parameter int unsigned MAX_SEGS    = 4,
   parameter int unsigned WORD_W      = 32,
   parameter int unsigned LEN_W       = 23,
   parameter int unsigned LOOP_W      = LOOP_W_DEF,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned BANK_BITS  = SEG_BITS * MAX_SEGS,
   localparam int unsigned WPB        = BANK_BITS / WORD_W,
   localparam int unsigned ADDR_W     = $clog2(WPB),
   localparam int unsigned IDX_W      = $clog2(BANK_BITS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_bank,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [WORD_W-1:0] wr_data,
   input  logic [LEN_W-1:0]  len_a,
   input  logic [LEN_W-1:0]  len_b,
   input  logic [LOOP_W-1:0] loops_a,
   input  logic [LOOP_W-1:0] loops_b,
   input  logic              run,
   input  logic              ext_mode,
   input  logic              ext_sel,
   output logic              dout,
   output logic              dv,
   output logic              sync,
   output logic              pat_is_b
);

   if ((SEG_BITS & (SEG_BITS - 1)) != 0 || SEG_BITS < 2) begin : g_bad_seg
      $error("SEG_BITS must be a power of two");
   end
   if (MAX_SEGS < 1) begin : g_bad_segs
      $error("MAX_SEGS must be at least 1");
   end
   if (WORD_W == 0 || (SEG_BITS % WORD_W) != 0 || WPB < 2) begin : g_bad_word
      $error("WORD_W must divide SEG_BITS and give at least two words per bank");
   end
   if (LEN_W <= $clog2(SEG_BITS)) begin : g_bad_len
      $error("LEN_W too narrow for one segment");
   end
   if (LOOP_W < 1) begin : g_bad_loop
      $error("LOOP_W must be at least 1");
   end

   logic [IDX_W-1:0]  last_idx [2];
   logic [LOOP_W-1:0] loops_eff [2];
   logic [LEN_W-1:0]  len_in [2];
   logic [LOOP_W-1:0] loops_in [2];

   assign len_in[0]   = len_a;
   assign len_in[1]   = len_b;
   assign loops_in[0] = loops_a;
   assign loops_in[1] = loops_b;

   for (genvar p = 0; p < 2; p++) begin : g_dec
      alt_len_decode #(
         .SEG_BITS (SEG_BITS),
         .MAX_SEGS (MAX_SEGS),
         .LEN_W    (LEN_W),
         .LOOP_W   (LOOP_W)
      ) dec_i (
         .len_i      (len_in[p]),
         .loops_i    (loops_in[p]),
         .last_idx_o (last_idx[p]),
         .loops_o    (loops_eff[p])
      );
   end

   logic ext_sel_s;

   alt_sync #(.STAGES(SYNC_STAGES)) sel_sync_i (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (ext_sel),
      .q_o   (ext_sel_s)
   );

   pat_sel_e         cur_pat;
   logic [IDX_W-1:0] cur_idx;
   logic             first_bit;

   alt_seq_ctrl #(
      .IDX_W  (IDX_W),
      .LOOP_W (LOOP_W)
   ) ctrl_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (run),
      .ext_mode  (ext_mode),
      .ext_sel_s (ext_sel_s),
      .last_a    (last_idx[0]),
      .last_b    (last_idx[1]),
      .loops_a   (loops_eff[0]),
      .loops_b   (loops_eff[1]),
      .cur_pat   (cur_pat),
      .cur_idx   (cur_idx),
      .first_bit (first_bit)
   );

   logic rd_bit;

   alt_pat_mem #(
      .WORD_W    (WORD_W),
      .BANK_BITS (BANK_BITS)
   ) mem_i (
      .clk     (clk),
      .wr_en   (wr_en),
      .wr_bank (wr_bank),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_bank (cur_pat == PAT_B),
      .rd_idx  (cur_idx),
      .rd_bit  (rd_bit)
   );

   always_ff @(posedge clk) begin
      if (!rst_n || !run) begin
         dout     <= 1'b0;
         dv       <= 1'b0;
         sync     <= 1'b0;
         pat_is_b <= 1'b0;
      end else begin
         dout     <= rd_bit;
         dv       <= 1'b1;
         sync     <= first_bit;
         pat_is_b <= (cur_pat == PAT_B);
      end
   end

endmodule

// File: rtl/alt_pattern_seq_chk.sv
module alt_pattern_seq_chk #(
   parameter int unsigned SEG_BITS = 128
) (
   input logic clk,
   input logic rst_n,
   input logic run,
   input logic dv,
   input logic dout,
   input logic sync,
   input logic pat_is_b
);

   localparam int unsigned SEG_SH = $clog2(SEG_BITS);

   logic [31:0] gap_q;
   logic        seen_q;

   always_ff @(posedge clk) begin
      if (!rst_n || !dv) begin
         gap_q  <= '0;
         seen_q <= 1'b0;
      end else if (sync) begin
         gap_q  <= 32'd1;
         seen_q <= 1'b1;
      end else begin
         gap_q <= gap_q + 32'd1;
      end
   end

   assert_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (!dv && !dout && !sync && !pat_is_b));

   assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run) |=> (dv && sync && !pat_is_b));

   assert_pass_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (sync && seen_q) |-> ((gap_q >= SEG_BITS) && (gap_q[SEG_SH-1:0] == '0)));

   assert_no_mid_switch_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (dv && $past(dv) && !sync) |-> (pat_is_b == $past(pat_is_b)));

   assert_sync_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
      sync |-> dv);

endmodule

bind alt_pattern_seq alt_pattern_seq_chk #(.SEG_BITS(SEG_BITS)) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .run      (run),
   .dv       (dv),
   .dout     (dout),
   .sync     (sync),
   .pat_is_b (pat_is_b)
);

// File: tb/alt_pattern_seq_tb_top.sv
module alt_pattern_seq_tb_top;

   localparam int SEGB  = 128;
   localparam int NSEG  = 4;
   localparam int WW    = 32;
   localparam int LW    = 23;
   localparam int PW    = 7;
   localparam int BANK  = SEGB * NSEG;
   localparam int NWORD = BANK / WW;
   localparam int AW    = $clog2(NWORD);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic          wr_bank = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [WW-1:0] wr_data = '0;
   logic [LW-1:0] len_a = LW'(128);
   logic [LW-1:0] len_b = LW'(128);
   logic [PW-1:0] loops_a = PW'(1);
   logic [PW-1:0] loops_b = PW'(1);
   logic          run = 1'b0;
   logic          ext_mode = 1'b0;
   logic          ext_sel = 1'b0;
   logic          dout, dv, sync, pat_is_b;

   always #5 clk = ~clk;

   alt_pattern_seq dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_bank(wr_bank),
      .wr_addr(wr_addr), .wr_data(wr_data), .len_a(len_a), .len_b(len_b),
      .loops_a(loops_a), .loops_b(loops_b), .run(run), .ext_mode(ext_mode),
      .ext_sel(ext_sel), .dout(dout), .dv(dv), .sync(sync), .pat_is_b(pat_is_b)
   );

   int total = 0;
   int bad = 0;
   logic [BANK-1:0] ref_bank [2];
   int epat, eidx, epass;
   bit ext_rand = 1'b0;

   function automatic int eff_len(input logic [LW-1:0] l);
      int s = int'(l) / SEGB;
      if (s == 0) s = 1;
      if (s > NSEG) s = NSEG;
      return s * SEGB;
   endfunction

   function automatic int eff_loops(input logic [PW-1:0] l);
      return (l == '0) ? 1 : int'(l);
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d (pat=%0d idx=%0d)", req, act, exp, epat, eidx);
      end
   endtask

   task automatic check_idle(input string req);
      check(!dv && !dout && !sync && !pat_is_b, req,
            {dv, dout, sync, pat_is_b}, 0);
   endtask

   task automatic step(input string req);
      int ebit = ref_bank[epat][eidx];
      int exp = {1'b1, 1'(ebit), 1'(eidx == 0), 1'(epat)};
      check(exp == {dv, dout, sync, pat_is_b}, req, {dv, dout, sync, pat_is_b}, exp);
      if (ext_rand && eidx == 64) ext_sel = 1'($urandom % 2);
      if (eidx == eff_len(epat ? len_b : len_a) - 1) begin
         eidx = 0;
         if (ext_mode) begin
            epat = int'(ext_sel);
            epass = 0;
         end else if (epass + 1 >= eff_loops(epat ? loops_b : loops_a)) begin
            epat = 1 - epat;
            epass = 0;
         end else begin
            epass++;
         end
      end else begin
         eidx++;
      end
   endtask

   task automatic play(input int ncyc, input string req);
      epat = 0; eidx = 0; epass = 0;
      @(negedge clk);
      run = 1'b1;
      repeat (ncyc) begin
         @(negedge clk);
         step(req);
      end
      run = 1'b0;
      @(negedge clk);
      check_idle("R11");
   endtask

   task automatic cfg(input int la, input int lb, input int pa, input int pb);
      len_a = LW'(la); len_b = LW'(lb);
      loops_a = PW'(pa); loops_b = PW'(pb);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_0A1B));
      repeat (3) @(negedge clk);
      check_idle("R1");
      run = 1'b1;
      @(negedge clk);
      check_idle("R1");
      run = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);
      check_idle("R1");

      // R3: load both banks through the word port
      for (int b = 0; b < 2; b++) begin
         for (int w = 0; w < NWORD; w++) begin
            wr_en = 1'b1; wr_bank = 1'(b); wr_addr = AW'(w);
            wr_data = $urandom;
            ref_bank[b][w*WW +: WW] = wr_data;
            @(negedge clk);
         end
      end
      wr_en = 1'b0;
      check_idle("R1");

      // R6: counting mode, two full cycles
      cfg(128, 256, 3, 2);
      play(2 * (3 * 128 + 2 * 256) + 50, "R6");

      // R4 / R7: rounding and zero loop counts
      cfg(300, 50, 0, 1);
      play(1200, "R4_R7");
      cfg(0, 255, 2, 0);
      play(900, "R4_R7");

      // R5: clamp to capacity, maximum loop count
      cfg(4194304, 700, 127, 1);
      play(127 * 512 + 512 + 300, "R5");

      // R2 / R11: stop mid-pass and restart
      cfg(128, 128, 2, 1);
      play(200, "R2");
      play(77, "R11");

      // random configurations
      for (int k = 0; k < 6; k++) begin
         cfg(int'($urandom % 700), int'($urandom % 700),
             int'($urandom % 4), int'($urandom % 4));
         play(2500, "R6_rand");
      end

      // R8: external select overrides loop counts
      ext_mode = 1'b1;
      ext_sel = 1'b0;
      ext_rand = 1'b1;
      cfg(128, 256, 5, 5);
      repeat (4) @(negedge clk);
      play(6000, "R8");
      ext_sel = 1'b1;
      repeat (4) @(negedge clk);
      ext_rand = 1'b0;
      play(1000, "R8");
      ext_mode = 1'b0;
      ext_sel = 1'b0;

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule